// File: doc/BRIEF.md
# Passive Monochrome LCD Strobe and Data Timing Generator

This block drives a single passive monochrome LCD panel. It produces the line strobe, the frame strobe, the shift clock and an alternating-polarity signal (MOD) from one pixel clock. It also places an 8-bit data byte on the panel bus for every shift clock, and each byte carries eight 1-bit pixels. Every interval is a whole number of pixel-clock cycles. The length of a line is built from two programmable amounts: the active width, in units of sixteen pixels, and a blanking amount, in units of eight cycles.

Pixel bytes come from an upstream source over a ready/valid handshake. The block raises `pix_ready` for one cycle at the start of each shift period inside the active window. If the source has no byte ready at that moment, the panel keeps the previous byte and a sticky underrun flag is set. A line-count setting defines the frame length. A mask setting decides whether the shift clock runs for the whole line or only while data is being shifted. The block samples all settings at reset and again at each frame boundary. A settings change therefore never tears a frame.

Top module: `lcd_mono_timing`

## Requirements
- R1: While `rst_n` is low, at each clock edge the outputs `lcd_line`, `lcd_frame`, `lcd_shift` and `lcd_mod` clear, `underrun` clears and `lcd_data` becomes 0. The first cycle after the first edge with `rst_n` high is position 0 of line 0 of a new frame. In that cycle `lcd_line` is high.
- R2: Consecutive rising edges of `lcd_line` are `(cfg_hsize+1)*16 + (cfg_hndp+4)*8` cycles apart. Positions p are counted from 0 at the cycle in which `lcd_line` rises.
- R3: `lcd_line` is high for positions 0 to 8, which is exactly 9 cycles.
- R4: `lcd_frame` is high from position 18 of the last line of a frame (line `cfg_vlast`) through position 17 of line 0. It is low at every other time. That places its set-up at one line period minus 9 before the falling edge of `lcd_line` in line 0, and its hold at 9 cycles after that edge.
- R5: `lcd_mod` toggles exactly once per line, at position 1, one cycle after `lcd_line` rises. It is 0 after reset.
- R6: With the mask set, `lcd_shift` is high at positions p with 32 <= p < 32+16*(cfg_hsize+1) and p mod 8 < 4, and low everywhere else. The first rise is therefore 23 cycles after `lcd_line` falls, each period is 4 high and 4 low, and there are 2*(cfg_hsize+1) pulses per line. The last fall comes 8*cfg_hndp+4 cycles before the next rise of `lcd_line`.
- R7: With the mask clear, `lcd_shift` is high at every position with p mod 8 < 4 across the whole line, including blanking.
- R8: `pix_ready` is high exactly at positions 31+8k, for k from 0 to 2*(cfg_hsize+1)-1. A byte accepted there drives `lcd_data` from position 32+8k through 39+8k, which is 4 cycles on each side of the shift fall. `lcd_data` does not change at any other time, whatever `pix_data` and `pix_valid` do.
- R9: If `pix_valid` is low in a `pix_ready` cycle, `lcd_data` keeps its previous byte and `underrun` goes high the next cycle. `underrun` stays high until reset.
- R10: A frame has `cfg_vlast+1` lines. The settings `cfg_hsize`, `cfg_hndp`, `cfg_vlast` and `cfg_smask` are taken only at reset and at position 0 of line 0. Changes made during a frame take effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_hsize | input | 6 | Active width in units of 16 pixels, minus one |
| cfg_hndp | input | 5 | Blanking amount in units of 8 cycles (line adds 4 more units) |
| cfg_vlast | input | 10 | Number of lines per frame minus one |
| cfg_smask | input | 1 | 1: shift clock only in the active window |
| pix_data | input | 8 | Pixel byte from the source |
| pix_valid | input | 1 | Source has a byte |
| pix_ready | output | 1 | Byte taken at this clock edge |
| lcd_line | output | 1 | Line strobe |
| lcd_frame | output | 1 | Frame strobe |
| lcd_shift | output | 1 | Shift clock |
| lcd_mod | output | 1 | Alternating-polarity signal |
| lcd_data | output | 8 | Panel data bus |
| underrun | output | 1 | Sticky: a fetch slot found no byte |

## Verification
Two things can land on the same edge. One is the frame-boundary capture of new settings. The other is the last line of the old frame, whose frame strobe, blanking length and final positions must still follow the old settings. The bench provokes this by changing every setting in the middle of a frame. It then uses a per-cycle model that swaps its own copy of the settings only on entry to line 0. Any early or late adoption shows up as a mismatch on the line or frame strobe. A second overlap is a missing byte in a fetch slot that coincides with the shift clock rising. There the bench checks that the held byte, the shift edge and the underrun flag each appear in their own expected cycle.

// File: rtl/lcd_mono_pkg.sv
// Package: lcd_mono_pkg
// Fixed offsets of the panel timing, all in pixel-clock cycles, counted from
// the position at which the line strobe rises. Assumes SHIFT_PERIOD is a
// power of two.
package lcd_mono_pkg;
    localparam int LINE_STROBE_LEN = 9;   // cycles the line strobe stays high
    localparam int FRAME_EDGE      = 18;  // frame strobe toggle position
    localparam int SHIFT_START     = 32;  // first shift rise position
    localparam int SHIFT_PERIOD    = 8;   // shift clock period
    localparam int SHIFT_HIGH      = 4;   // high cycles per shift period
    localparam int MOD_EDGE        = 1;   // position at which MOD toggles
    localparam int ACT_UNIT_SHIFT  = 4;   // active width unit = 16 cycles
    localparam int BLANK_UNIT_SHIFT = 3;  // blanking unit = 8 cycles
    localparam int BLANK_EXTRA     = 4;   // fixed blanking units per line

    // Registered panel strobes produced together
    typedef struct packed {
        logic line;
        logic frame;
        logic shift;
    } strobe_t;
endpackage

// File: rtl/lcd_cfg_shadow.sv
// Module: lcd_cfg_shadow
// Holds the working copy of the settings. The copy is loaded from the
// inputs during reset and whenever load is high (the last cycle of a
// frame), so a frame always runs with one consistent set.
module lcd_cfg_shadow #(
    parameter int SIZE_W = 6,
    parameter int NDP_W  = 5,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [NDP_W-1:0]  in_ndp,
    input  logic [LINE_W-1:0] in_vlast,
    input  logic              in_mask,
    output logic [SIZE_W-1:0] sh_size,
    output logic [NDP_W-1:0]  sh_ndp,
    output logic [LINE_W-1:0] sh_vlast,
    output logic              sh_mask
);
    // Capture the settings at reset and at each frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sh_size  <= in_size;
            sh_ndp   <= in_ndp;
            sh_vlast <= in_vlast;
            sh_mask  <= in_mask;
        end
    end
endmodule

// File: rtl/lcd_timebase.sv
// Module: lcd_timebase
// Horizontal position counter and line counter. The module also decodes
// where in the line the active shift window lies. Assumes that
// H_W is wide enough for the longest line the settings allow.
module lcd_timebase
    import lcd_mono_pkg::*;
#(
    parameter int SIZE_W = 6,
    parameter int NDP_W  = 5,
    parameter int LINE_W = 10,
    parameter int H_W    = 11,
    parameter int PH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] size,
    input  logic [NDP_W-1:0]  ndp,
    input  logic [LINE_W-1:0] vlast,
    output logic [H_W-1:0]    hpos,
    output logic [LINE_W-1:0] line,
    output logic [PH_W-1:0]   phase,
    output logic              in_act,
    output logic              fetch,
    output logic              frame_end
);
    localparam logic [H_W-1:0]    H_ONE    = H_W'(1);
    localparam logic [H_W-1:0]    H_BLANKX = H_W'(BLANK_EXTRA);
    localparam logic [H_W-1:0]    H_START  = H_W'(SHIFT_START);
    localparam logic [LINE_W-1:0] L_ONE    = LINE_W'(1);

    logic [H_W-1:0] line_len;
    logic [H_W-1:0] act_end;
    logic           line_end;

    // Line length and end of the active window for the working settings
    always_comb begin
        line_len = ((H_W'(size) + H_ONE) << ACT_UNIT_SHIFT)
                 + ((H_W'(ndp) + H_BLANKX) << BLANK_UNIT_SHIFT);
        act_end  = H_START + ((H_W'(size) + H_ONE) << ACT_UNIT_SHIFT);
    end

    // Window and boundary decode of the current position
    always_comb begin
        phase     = hpos[PH_W-1:0];
        in_act    = (hpos >= H_START) && (hpos < act_end);
        fetch     = in_act && (phase == '0);
        line_end  = (hpos == line_len - H_ONE);
        frame_end = line_end && (line == vlast);
    end

    // Advance position and line, wrapping at line and frame ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= '0;
            line <= '0;
        end else if (line_end) begin
            hpos <= '0;
            line <= frame_end ? '0 : line + L_ONE;
        end else begin
            hpos <= hpos + H_ONE;
        end
    end
endmodule

// File: rtl/lcd_strobe_gen.sv
// Module: lcd_strobe_gen
// Turns the position and line into the registered line, frame and shift
// strobes and the MOD signal. Every strobe passes through one register,
// so all of them lag the counter by exactly one cycle.
module lcd_strobe_gen
    import lcd_mono_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int H_W    = 11,
    parameter int PH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [H_W-1:0]    hpos,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] vlast,
    input  logic [PH_W-1:0]   phase,
    input  logic              in_act,
    input  logic              mask,
    output strobe_t           strobe,
    output logic              mod
);
    localparam logic [H_W-1:0]  H_LINE_LEN = H_W'(LINE_STROBE_LEN);
    localparam logic [H_W-1:0]  H_FRAME    = H_W'(FRAME_EDGE);
    localparam logic [H_W-1:0]  H_MOD      = H_W'(MOD_EDGE);
    localparam logic [PH_W-1:0] P_HIGH     = PH_W'(SHIFT_HIGH);

    strobe_t nxt;
    logic    phase_high;

    // Next strobe values from the current position
    always_comb begin
        phase_high = (phase < P_HIGH);
        nxt.line   = (hpos < H_LINE_LEN);
        nxt.frame  = ((line == vlast) && (hpos >= H_FRAME))
                   || ((line == '0) && (hpos < H_FRAME));
        nxt.shift  = phase_high && (in_act || !mask);
    end

    // Register the strobes and toggle MOD once per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= '0;
            mod    <= 1'b0;
        end else begin
            strobe <= nxt;
            if (hpos == H_MOD) mod <= !mod;
        end
    end
endmodule

// File: rtl/lcd_pixel_path.sv
// Module: lcd_pixel_path
// Takes one byte per fetch slot from the ready/valid source and holds it on
// the panel bus for a full shift period. A missing byte leaves the bus
// unchanged and sets the sticky underrun flag.
module lcd_pixel_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic [DATA_W-1:0] bus,
    output logic              underrun
);
    // Offer the slot to the source exactly in fetch cycles
    always_comb pix_ready = fetch;

    // Capture the byte or flag its absence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus      <= '0;
            underrun <= 1'b0;
        end else if (fetch) begin
            if (pix_valid) bus <= pix_data;
            else           underrun <= 1'b1;
        end
    end
endmodule

// File: rtl/lcd_mono_timing.sv
// Module: lcd_mono_timing (top)
// Timing generator for a passive monochrome panel with an 8-bit data bus.
// It chains the settings shadow, the counters, the strobe registers and the
// pixel path. Assumes that clk is the pixel clock and that the reset is
// synchronous and active low.
module lcd_mono_timing
    import lcd_mono_pkg::*;
#(
    parameter int SIZE_W = 6,
    parameter int NDP_W  = 5,
    parameter int LINE_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] cfg_hsize,
    input  logic [NDP_W-1:0]  cfg_hndp,
    input  logic [LINE_W-1:0] cfg_vlast,
    input  logic              cfg_smask,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic              lcd_line,
    output logic              lcd_frame,
    output logic              lcd_shift,
    output logic              lcd_mod,
    output logic [DATA_W-1:0] lcd_data,
    output logic              underrun
);
    localparam int MAX_LINE = (2 ** SIZE_W) * (1 << ACT_UNIT_SHIFT)
                            + (2 ** NDP_W + BLANK_EXTRA - 1) * (1 << BLANK_UNIT_SHIFT);
    localparam int H_W  = $clog2(MAX_LINE + 1);
    localparam int PH_W = $clog2(SHIFT_PERIOD);

    logic [SIZE_W-1:0] sh_size;
    logic [NDP_W-1:0]  sh_ndp;
    logic [LINE_W-1:0] sh_vlast;
    logic              sh_mask;
    logic [H_W-1:0]    hpos;
    logic [LINE_W-1:0] line;
    logic [PH_W-1:0]   phase;
    logic              in_act;
    logic              fetch;
    logic              frame_end;
    strobe_t           strobe;

    lcd_cfg_shadow #(.SIZE_W(SIZE_W), .NDP_W(NDP_W), .LINE_W(LINE_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(frame_end),
        .in_size(cfg_hsize), .in_ndp(cfg_hndp), .in_vlast(cfg_vlast), .in_mask(cfg_smask),
        .sh_size(sh_size), .sh_ndp(sh_ndp), .sh_vlast(sh_vlast), .sh_mask(sh_mask)
    );

    lcd_timebase #(.SIZE_W(SIZE_W), .NDP_W(NDP_W), .LINE_W(LINE_W), .H_W(H_W), .PH_W(PH_W)) u_time (
        .clk(clk), .rst_n(rst_n), .size(sh_size), .ndp(sh_ndp), .vlast(sh_vlast),
        .hpos(hpos), .line(line), .phase(phase), .in_act(in_act), .fetch(fetch),
        .frame_end(frame_end)
    );

    lcd_strobe_gen #(.LINE_W(LINE_W), .H_W(H_W), .PH_W(PH_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .hpos(hpos), .line(line), .vlast(sh_vlast),
        .phase(phase), .in_act(in_act), .mask(sh_mask), .strobe(strobe), .mod(lcd_mod)
    );

    lcd_pixel_path #(.DATA_W(DATA_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .fetch(fetch), .pix_data(pix_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .bus(lcd_data), .underrun(underrun)
    );

    // Unpack the registered strobes onto the panel pins
    always_comb begin
        lcd_line  = strobe.line;
        lcd_frame = strobe.frame;
        lcd_shift = strobe.shift;
    end
endmodule

// File: rtl/lcd_mono_timing_chk.sv
// Module: lcd_mono_timing_chk
// Temporal checks on the ports of lcd_mono_timing plus the working mask
// bit. A bind statement at the end of this file attaches it to the top module.
module lcd_mono_timing_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_ready,
    input logic              pix_valid,
    input logic              lcd_line,
    input logic              lcd_frame,
    input logic              lcd_shift,
    input logic              lcd_mod,
    input logic [DATA_W-1:0] lcd_data,
    input logic              underrun,
    input logic              mask_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!lcd_line && !lcd_frame && !lcd_shift && !lcd_mod && !underrun && lcd_data == '0));

    p_line_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_line) |-> ($past(lcd_line, 9) && !$past(lcd_line, 10)));

    p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_frame) |-> (!$past(lcd_line, 9) && $past(lcd_line, 10)));

    p_mod_after_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lcd_mod) |-> ($past(lcd_line) && !$past(lcd_line, 2)));

    p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && lcd_line) |-> !lcd_shift);

    p_ready_then_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |=> $rose(lcd_shift));

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_ready) |-> $stable(lcd_data));

    p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid) |=> underrun);
endmodule

bind lcd_mono_timing lcd_mono_timing_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .pix_valid(pix_valid),
    .lcd_line(lcd_line), .lcd_frame(lcd_frame), .lcd_shift(lcd_shift),
    .lcd_mod(lcd_mod), .lcd_data(lcd_data), .underrun(underrun), .mask_q(sh_mask)
);

// File: tb/test_lcd_mono_timing.sv
`timescale 1ns/1ps
// Bench: sweeps width, blanking and mask over small values and compares every
// output in every cycle against an arithmetic model of the line positions.
module test_lcd_mono_timing;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_hsize = '0;
    logic [4:0] cfg_hndp = '0;
    logic [9:0] cfg_vlast = '0;
    logic       cfg_smask = 1'b0;
    logic [7:0] pix_data = '0;
    logic       pix_valid = 1'b0;
    logic       pix_ready, lcd_line, lcd_frame, lcd_shift, lcd_mod, underrun;
    logic [7:0] lcd_data;

    int n_tests = 0;
    int n_fail  = 0;
    // model state
    int  cs, cn, cv, cm;      // settings in force
    int  ns, nn, nv, nm;      // settings waiting for the next frame
    int  p, ln, len;
    int  cyc = 0;
    bit  e_mod, e_und, drop_req;
    int  e_dat;

    lcd_mono_timing i_lcd_mono_timing (
        .clk(clk), .rst_n(rst_n), .cfg_hsize(cfg_hsize), .cfg_hndp(cfg_hndp),
        .cfg_vlast(cfg_vlast), .cfg_smask(cfg_smask), .pix_data(pix_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .lcd_line(lcd_line),
        .lcd_frame(lcd_frame), .lcd_shift(lcd_shift), .lcd_mod(lcd_mod),
        .lcd_data(lcd_data), .underrun(underrun)
    );

    always #2 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (line %0d pos %0d)", req, what, act, exp, ln, p);
        end
    endtask

    function automatic int line_len(int s, int n);
        return (s + 1) * 16 + (n + 4) * 8;
    endfunction

    function automatic bit ready_at(int pos);
        int c = (pos + 1) % len;
        return (c >= 32) && (c < 32 + 16 * (cs + 1)) && (c % 8 == 0);
    endfunction

    task automatic set_cfg(int s, int n, int v, int m);
        cfg_hsize = 6'(s); cfg_hndp = 5'(n); cfg_vlast = 10'(v); cfg_smask = 1'(m);
        ns = s; nn = n; nv = v; nm = m;
    endtask

    task automatic do_reset(int s, int n, int v, int m);
        @(negedge clk);
        rst_n = 1'b0;
        pix_valid = 1'b0;
        set_cfg(s, n, v, m);
        repeat (4) @(negedge clk);
        // R1: everything cleared while in reset
        chk("R1", "line", int'(lcd_line), 0);
        chk("R1", "frame", int'(lcd_frame), 0);
        chk("R1", "shift", int'(lcd_shift), 0);
        chk("R1", "mod", int'(lcd_mod), 0);
        chk("R1", "data", int'(lcd_data), 0);
        chk("R1", "underrun", int'(underrun), 0);
        cs = s; cn = n; cv = v; cm = m;
        len = line_len(cs, cn);
        p = 0; ln = 0; e_mod = 0; e_und = 0; e_dat = 0; drop_req = 0;
        rst_n = 1'b1;
    endtask

    task automatic step();
        bit e_line, e_frame, e_shift, e_rdy;
        @(negedge clk);
        cyc++;
        e_line  = (p < 9);                                              // R2 R3
        e_frame = ((ln == cv) && (p >= 18)) || ((ln == 0) && (p < 18)); // R4 R10
        e_shift = (p % 8 < 4) &&
                  ((cm == 0) || ((p >= 32) && (p < 32 + 16 * (cs + 1)))); // R6 R7
        e_rdy   = ready_at(p);                                          // R8
        chk("R3", "line", int'(lcd_line), int'(e_line));
        chk("R4", "frame", int'(lcd_frame), int'(e_frame));
        chk(cm ? "R6" : "R7", "shift", int'(lcd_shift), int'(e_shift));
        chk("R5", "mod", int'(lcd_mod), int'(e_mod));
        chk("R8", "ready", int'(pix_ready), int'(e_rdy));
        chk("R8", "data", int'(lcd_data), e_dat);
        chk("R9", "underrun", int'(underrun), int'(e_und));
        // drive the source for the coming edge; data changes every cycle
        pix_data = 8'(cyc * 37 + 5);
        pix_valid = 1'b1;
        if (e_rdy && drop_req) begin
            pix_valid = 1'b0;
            drop_req = 0;
        end
        if (e_rdy) begin
            if (pix_valid) e_dat = int'(pix_data);
            else           e_und = 1;
        end
        // advance model position
        p++;
        if (p == len) begin
            p = 0;
            if (ln == cv) begin
                ln = 0;
                cs = ns; cn = nn; cv = nv; cm = nm;   // R10
                len = line_len(cs, cn);
            end else begin
                ln++;
            end
        end
        if (p == 1) e_mod = !e_mod;
    endtask

    initial begin
        for (int s = 0; s <= 2; s++) begin
            for (int n = 0; n <= 2; n += 2) begin
                for (int m = 0; m <= 1; m++) begin
                    do_reset(s, n, 1, m);
                    repeat (2 * line_len(s, n)) step();
                    drop_req = 1;                 // R9: one missing byte
                    repeat (2 * line_len(s, n) + 12) step();
                end
            end
        end
        // R10: settings changed mid-frame take effect at the next frame only
        do_reset(1, 1, 2, 1);
        repeat (50) step();
        set_cfg(0, 0, 0, 0);
        repeat (700) step();
        // single-line frames with mask set, then a late drop
        set_cfg(2, 3, 0, 1);
        repeat (400) step();
        drop_req = 1;
        repeat (200) step();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(400000);
        n_fail++;
        $display("FAIL watchdog: run did not end");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule